// File: doc/BRIEF.md
# Synchronous Cache Tag Memory with Match Comparator

This block is a clocked single-port memory of 18-bit words, organised as two 9-bit lanes. It can hold cache tags and also serve as plain data storage. All of its commands are sampled on the rising clock edge: address, write data, the three chip enables, the write controls and the compare request.

A compare command reads the addressed word internally and checks it against the tag that was presented on `data_i` and captured in the input register. The result appears on a match flag, and the read-data outputs stay disabled for that command. A timing-mode input selects one of two timings for both read data and the match flag. In flow-through timing the result appears after the sampling edge. In pipelined timing it passes through an extra output register and appears one edge later.

A deselect is pipelined to the same depth as a read. The outputs keep their previous content for one more cycle and turn off only at the following edge. The output enables act combinationally. They gate valid flags that stand in for tri-state drivers.

Top module: `tag_sram_cmp`

## Requirements
- R1: The block is selected only when `ce0_n_i`=0, `ce1_i`=1 and `ce2_n_i`=0 at a rising edge. An unselected edge writes nothing.
- R2: When `byte_wr_en_i`=1 on a selected edge, each lane k whose `lane_strb_i[k]`=1 takes `data_i[9k+8:9k]`. Lane 0 is bits 8:0 and lane 1 is bits 17:9. Lanes whose strobe is 0 keep their content, so an all-zero strobe changes nothing.
- R3: When `glb_wr_i`=1 on a selected edge, all 18 bits are written, regardless of `byte_wr_en_i` and `lane_strb_i`.
- R4: With `flow_i`=1, a read drives `rdata_vld_o`=1 with the stored word after its sampling edge. With `flow_i`=0, this happens after the next edge instead.
- R5: A compare (`cmp_i`=1, selected, no write) keeps `rdata_vld_o`=0. At the same latency as a read, it drives `match_vld_o`=1, with `match_o`=1 exactly when the stored word equals the `data_i` sampled with the compare.
- R6: A write cycle gives no valid output. A compare requested together with a write is performed as a write only.
- R7: After a deselect edge, the outputs repeat the previous command's result for one more cycle. A second consecutive deselect edge turns them off. In pipelined timing the whole sequence is shifted by one edge.
- R8: `oe_i`=0 forces `rdata_vld_o`=0 and `rdata_o`=0 combinationally. `match_oe_i`=0 forces `match_vld_o`=0 and `match_o`=0 combinationally.
- R9: While `rst_ni`=0, all valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce0_n_i | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_n_i | input | 1 | Chip enable, active low |
| addr_i | input | AW (8) | Word address |
| data_i | input | 18 | Write data or compare tag |
| glb_wr_i | input | 1 | Write all lanes |
| byte_wr_en_i | input | 1 | Enable lane-strobed write |
| lane_strb_i | input | 2 | Per-lane write strobes |
| cmp_i | input | 1 | Compare request |
| flow_i | input | 1 | 1 = flow-through, 0 = pipelined |
| oe_i | input | 1 | Read-data output enable |
| match_oe_i | input | 1 | Match output enable |
| rdata_o | output | 18 | Read data, zero when not valid |
| rdata_vld_o | output | 1 | Read data driven |
| match_o | output | 1 | Compare result, zero when not valid |
| match_vld_o | output | 1 | Match flag driven |

## Verification
The assertions check on every cycle the properties that hold in any state:
- the combinational gating by both output enables;
- the exclusion of read data and match flag;
- the absence of valid output after a write or a compare in flow-through timing;
- the turn-off after two consecutive deselect edges;
- quiet outputs during reset.

Only the bench scenarios can show the following:
- the stored values, including the effect of lane strobes, global writes and writes from unselected cycles;
- the exact match result;
- the one-edge latency difference between the two timings;
- the held cycle that follows a single deselect.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_CMP   = 2'd2,
    OP_WRITE = 2'd3
  } tag_op_e;
endpackage

// File: rtl/tag_cmd_dec.sv
module tag_cmd_dec
  import tag_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce0_n_i,
  input  logic             ce1_i,
  input  logic             ce2_n_i,
  input  logic             glb_wr_i,
  input  logic             byte_wr_en_i,
  input  logic [LANES-1:0] lane_strb_i,
  input  logic             cmp_i,
  output tag_op_e          op_o,
  output logic [LANES-1:0] wr_lanes_o,
  output logic             desel_o
);
  logic sel, wr;

  assign sel     = ~ce0_n_i & ce1_i & ~ce2_n_i;
  assign wr      = sel & (glb_wr_i | byte_wr_en_i);
  assign desel_o = ~sel;

  // global write outranks lane strobes
  always_comb begin
    wr_lanes_o = '0;
    if (wr) wr_lanes_o = glb_wr_i ? {LANES{1'b1}} : lane_strb_i;
  end

  // write outranks compare
  always_comb begin
    if (!sel)       op_o = OP_IDLE;
    else if (wr)    op_o = OP_WRITE;
    else if (cmp_i) op_o = OP_CMP;
    else            op_o = OP_READ;
  end
endmodule

// File: rtl/tag_cmd_stage.sv
module tag_cmd_stage
  import tag_pkg::*;
#(
  parameter int AW     = 8,
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tag_op_e           op_i,
  input  logic              desel_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] data_i,
  output tag_op_e           op_o,
  output logic [AW-1:0]     addr_o,
  output logic [WORD_W-1:0] din_o
);
  tag_op_e           op_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] din_q;
  logic              hold_q;

  // first deselect holds the previous command, the second retires it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      din_q  <= '0;
      hold_q <= 1'b0;
    end else if (desel_i) begin
      if (hold_q) op_q <= OP_IDLE;
      hold_q <= 1'b1;
    end else begin
      op_q   <= op_i;
      addr_q <= addr_i;
      din_q  <= data_i;
      hold_q <= 1'b0;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign din_o  = din_q;
endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  wr_lanes_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_lanes_i[k]) mem[waddr_i] <= wdata_i[k*LANE_W +: LANE_W];
    end

    assign rdata_o[k*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/tag_out_path.sv
module tag_out_path
  import tag_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tag_op_e           op_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] tag_i,
  input  logic              flow_i,
  input  logic              oe_i,
  input  logic              match_oe_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              match_o,
  output logic              match_vld_o
);
  tag_op_e           op_q;
  logic [WORD_W-1:0] word_q;
  logic              hit_q;
  logic              hit;
  tag_op_e           out_op;
  logic [WORD_W-1:0] out_word;
  logic              out_hit;

  assign hit = (word_i == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      word_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      op_q   <= op_i;
      word_q <= word_i;
      hit_q  <= hit;
    end
  end

  assign out_op   = flow_i ? op_i   : op_q;
  assign out_word = flow_i ? word_i : word_q;
  assign out_hit  = flow_i ? hit    : hit_q;

  assign rdata_vld_o = oe_i & (out_op == OP_READ);
  assign rdata_o     = rdata_vld_o ? out_word : '0;
  assign match_vld_o = match_oe_i & (out_op == OP_CMP);
  assign match_o     = match_vld_o & out_hit;
endmodule

// File: rtl/tag_sram_cmp.sv
module tag_sram_cmp
  import tag_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              ce2_n_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              glb_wr_i,
  input  logic              byte_wr_en_i,
  input  logic [LANES-1:0]  lane_strb_i,
  input  logic              cmp_i,
  input  logic              flow_i,
  input  logic              oe_i,
  input  logic              match_oe_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              match_o,
  output logic              match_vld_o
);
  tag_op_e           dec_op, s1_op;
  logic [LANES-1:0]  wr_lanes;
  logic              desel;
  logic [AW-1:0]     s1_addr;
  logic [WORD_W-1:0] s1_din;
  logic [WORD_W-1:0] rd_word;

  tag_cmd_dec #(.LANES(LANES)) u_dec (
    .ce0_n_i      (ce0_n_i),
    .ce1_i        (ce1_i),
    .ce2_n_i      (ce2_n_i),
    .glb_wr_i     (glb_wr_i),
    .byte_wr_en_i (byte_wr_en_i),
    .lane_strb_i  (lane_strb_i),
    .cmp_i        (cmp_i),
    .op_o         (dec_op),
    .wr_lanes_o   (wr_lanes),
    .desel_o      (desel)
  );

  tag_cmd_stage #(.AW(AW), .WORD_W(WORD_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (dec_op),
    .desel_i (desel),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .op_o    (s1_op),
    .addr_o  (s1_addr),
    .din_o   (s1_din)
  );

  tag_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk_i      (clk_i),
    .wr_lanes_i (wr_lanes),
    .waddr_i    (addr_i),
    .wdata_i    (data_i),
    .raddr_i    (s1_addr),
    .rdata_o    (rd_word)
  );

  tag_out_path #(.WORD_W(WORD_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (s1_op),
    .word_i      (rd_word),
    .tag_i       (s1_din),
    .flow_i      (flow_i),
    .oe_i        (oe_i),
    .match_oe_i  (match_oe_i),
    .rdata_o     (rdata_o),
    .rdata_vld_o (rdata_vld_o),
    .match_o     (match_o),
    .match_vld_o (match_vld_o)
  );
endmodule

// File: rtl/tag_sram_cmp_chk.sv
module tag_sram_cmp_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce0_n_i,
  input logic              ce1_i,
  input logic              ce2_n_i,
  input logic              glb_wr_i,
  input logic              byte_wr_en_i,
  input logic              cmp_i,
  input logic              flow_i,
  input logic              oe_i,
  input logic              match_oe_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rdata_vld_o,
  input logic              match_o,
  input logic              match_vld_o
);
  logic sel, prev_desel_q;

  assign sel = ~ce0_n_i & ce1_i & ~ce2_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_desel_q <= 1'b0;
    else         prev_desel_q <= ~sel;
  end

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!rdata_vld_o && rdata_o == '0));

  assert_moe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_oe_i |-> (!match_vld_o && !match_o));

  assert_cmp_no_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && cmp_i && !glb_wr_i && !byte_wr_en_i) |=> (!flow_i || !rdata_vld_o));

  assert_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdata_vld_o && match_vld_o));

  assert_write_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && (glb_wr_i || byte_wr_en_i)) |=> (!flow_i || (!rdata_vld_o && !match_vld_o)));

  assert_desel_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_desel_q && !sel) |=> (!flow_i || (!rdata_vld_o && !match_vld_o)));

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R9: assert (!rdata_vld_o && !match_vld_o);
  end
endmodule

bind tag_sram_cmp tag_sram_cmp_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce0_n_i      (ce0_n_i),
  .ce1_i        (ce1_i),
  .ce2_n_i      (ce2_n_i),
  .glb_wr_i     (glb_wr_i),
  .byte_wr_en_i (byte_wr_en_i),
  .cmp_i        (cmp_i),
  .flow_i       (flow_i),
  .oe_i         (oe_i),
  .match_oe_i   (match_oe_i),
  .rdata_o      (rdata_o),
  .rdata_vld_o  (rdata_vld_o),
  .match_o      (match_o),
  .match_vld_o  (match_vld_o)
);

// File: tb/tag_sram_cmp_tb_top.sv
`timescale 1ns/1ps
module tag_sram_cmp_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int W     = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  data = '0;
  logic          glb = 1'b0, bwe = 1'b0, cmp = 1'b0;
  logic [1:0]    strb = 2'b00;
  logic          flow = 1'b1, oe = 1'b1, moe = 1'b1;
  logic [W-1:0]  rdata;
  logic          rvld, match, mvld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tag_sram_cmp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce0_n_i(ce0_n), .ce1_i(ce1), .ce2_n_i(ce2_n),
    .addr_i(addr), .data_i(data), .glb_wr_i(glb), .byte_wr_en_i(bwe),
    .lane_strb_i(strb), .cmp_i(cmp), .flow_i(flow), .oe_i(oe), .match_oe_i(moe),
    .rdata_o(rdata), .rdata_vld_o(rvld), .match_o(match), .match_vld_o(mvld)
  );

  typedef struct packed {
    logic          flow;
    logic [1:0]    kind;   // 0 read, 1 compare, 2 lane write, 3 global write
    logic [AW-1:0] addr;
    logic [W-1:0]  data;
    logic [1:0]    strb;
    logic          evld;
    logic [W-1:0]  edata;
    logic          emvld;
    logic          ematch;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd3, 8'd5,   18'h2A5A5, 2'b00, 1'b0, 18'h0,     1'b0, 1'b0},
    '{1'b1, 2'd0, 8'd5,   18'h0,     2'b00, 1'b1, 18'h2A5A5, 1'b0, 1'b0},
    '{1'b1, 2'd2, 8'd5,   18'h3FFFF, 2'b01, 1'b0, 18'h0,     1'b0, 1'b0},
    '{1'b0, 2'd0, 8'd5,   18'h0,     2'b00, 1'b1, 18'h2A5FF, 1'b0, 1'b0},
    '{1'b0, 2'd2, 8'd5,   18'h0,     2'b10, 1'b0, 18'h0,     1'b0, 1'b0},
    '{1'b1, 2'd0, 8'd5,   18'h0,     2'b00, 1'b1, 18'h001FF, 1'b0, 1'b0},
    '{1'b0, 2'd1, 8'd5,   18'h001FF, 2'b00, 1'b0, 18'h0,     1'b1, 1'b1},
    '{1'b1, 2'd1, 8'd5,   18'h001FE, 2'b00, 1'b0, 18'h0,     1'b1, 1'b0},
    '{1'b1, 2'd2, 8'd5,   18'h0,     2'b00, 1'b0, 18'h0,     1'b0, 1'b0},
    '{1'b1, 2'd0, 8'd5,   18'h0,     2'b00, 1'b1, 18'h001FF, 1'b0, 1'b0},
    '{1'b0, 2'd3, 8'd255, 18'h3FFFF, 2'b00, 1'b0, 18'h0,     1'b0, 1'b0},
    '{1'b0, 2'd1, 8'd255, 18'h3FFFF, 2'b00, 1'b0, 18'h0,     1'b1, 1'b1}
  };

  function automatic logic [W-1:0] pat(input int a);
    return W'((a * 32'h9E3) ^ 32'h15A5);
  endfunction

  function automatic logic [W+2:0] obs();
    return {rvld, mvld, match, rdata};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input bit s, input bit g, input bit b, input logic [1:0] st,
                       input bit c, input logic [AW-1:0] a, input logic [W-1:0] d);
    ce0_n = ~s; ce1 = s; ce2_n = ~s;
    glb = g; bwe = b; strb = st; cmp = c; addr = a; data = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, '0, '0);
  endtask

  task automatic read_flow(input logic [AW-1:0] a, input logic [W-1:0] exp, input string req);
    flow = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, a, '0);
    tick();
    chk(rvld && rdata == exp, req, {13'd0, obs()}, {14'd1, exp});
    idle(); tick(); tick();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: quiet during reset
    @(negedge clk); @(negedge clk);
    chk(!rvld && !mvld, "R9", {30'd0, rvld, mvld}, 32'd0);
    rst_n = 1'b1;
    tick();
    chk(!rvld && !mvld && !match && rdata == '0, "R9", {11'd0, obs()}, 32'd0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      flow = VEC[i].flow;
      case (VEC[i].kind)
        2'd0: drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, VEC[i].addr, VEC[i].data);
        2'd1: drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, VEC[i].addr, VEC[i].data);
        2'd2: drive(1'b1, 1'b0, 1'b1, VEC[i].strb, 1'b0, VEC[i].addr, VEC[i].data);
        default: drive(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, VEC[i].addr, VEC[i].data);
      endcase
      tick();
      if (VEC[i].flow)
        chk(obs() == {VEC[i].evld, VEC[i].emvld, VEC[i].ematch, VEC[i].edata},
            $sformatf("R4/R5 vec %0d", i), {11'd0, obs()},
            {11'd0, VEC[i].evld, VEC[i].emvld, VEC[i].ematch, VEC[i].edata});
      else
        chk(!rvld && !mvld, $sformatf("R4 pipe early vec %0d", i), {30'd0, rvld, mvld}, 32'd0);
      idle(); tick();
      if (!VEC[i].flow)
        chk(obs() == {VEC[i].evld, VEC[i].emvld, VEC[i].ematch, VEC[i].edata},
            $sformatf("R4/R5 vec %0d", i), {11'd0, obs()},
            {11'd0, VEC[i].evld, VEC[i].emvld, VEC[i].ematch, VEC[i].edata});
      tick(); tick();
    end

    // R1: each single inactive enable blocks a global write
    flow = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 8'd7, 18'h12345);
    tick(); idle(); tick(); tick();
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 8'd7, 18'h0);
      if (k == 0) ce0_n = 1'b1;
      if (k == 1) ce1 = 1'b0;
      if (k == 2) ce2_n = 1'b1;
      tick();
      idle(); tick(); tick();
      read_flow(8'd7, 18'h12345, $sformatf("R1 enable %0d", k));
    end

    // R6: compare together with write is a write
    drive(1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 8'd9, 18'h0ABCD);
    tick();
    chk(!rvld && !mvld, "R6 no output", {30'd0, rvld, mvld}, 32'd0);
    idle(); tick(); tick();
    read_flow(8'd9, 18'h0ABCD, "R6 stored");

    // R7: deselect hold, flow-through
    flow = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'd7, '0);
    tick();
    chk(rvld && rdata == 18'h12345, "R7 flow first", {13'd0, obs()}, 32'h0);
    idle(); tick();
    chk(rvld && rdata == 18'h12345, "R7 flow held", {13'd0, obs()}, 32'h0);
    tick();
    chk(!rvld, "R7 flow off", {31'd0, rvld}, 32'd0);
    tick();

    // R7: deselect hold, pipelined
    flow = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'd9, '0);
    tick();
    chk(!rvld, "R7 pipe early", {31'd0, rvld}, 32'd0);
    idle(); tick();
    chk(rvld && rdata == 18'h0ABCD, "R7 pipe first", {13'd0, obs()}, 32'h0);
    tick();
    chk(rvld && rdata == 18'h0ABCD, "R7 pipe held", {13'd0, obs()}, 32'h0);
    tick();
    chk(!rvld, "R7 pipe off", {31'd0, rvld}, 32'd0);

    // R8: combinational output enables
    flow = 1'b1; oe = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8'd7, '0);
    tick();
    chk(!rvld && rdata == '0, "R8 oe low", {13'd0, obs()}, 32'd0);
    oe = 1'b1; #1;
    chk(rvld && rdata == 18'h12345, "R8 oe high", {13'd0, obs()}, 32'h0);
    moe = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8'd7, 18'h12345);
    tick();
    chk(!mvld && !match, "R8 moe low", {30'd0, mvld, match}, 32'd0);
    moe = 1'b1; #1;
    chk(mvld && match, "R8 moe high", {30'd0, mvld, match}, 32'd3);
    idle(); tick(); tick();

    // R3 R4: whole array, back-to-back writes then reads in both timings
    for (int a = 0; a < DEPTH; a++) begin
      drive(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, AW'(a), pat(a));
      tick();
    end
    flow = 1'b0;
    for (int a = 0; a <= DEPTH; a++) begin
      if (a < DEPTH) drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, AW'(a), '0);
      else idle();
      tick();
      if (a > 0)
        chk(rvld && rdata == pat(a - 1), "R4 pipe sweep", {13'd0, obs()}, {14'd1, pat(a - 1)});
    end
    idle(); tick(); tick();
    flow = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      drive(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, AW'(a), '0);
      tick();
      chk(rvld && rdata == pat(a), "R3 flow sweep", {13'd0, obs()}, {14'd1, pat(a)});
    end
    idle(); tick(); tick();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule